// File: doc/BRIEF.md
# FPGA Configuration Load Sequencer

This controller drives a JTAG shift engine through one complete configuration load of a programmable device. Each request on `start` runs a fixed seven-step program. First it loads the clear-configuration instruction and waits a long idle period. Next it selects the configuration-input instruction and sends the whole payload as a single data-register shift. It then loads the start instruction, waits a shorter idle period, and finally parks the TAP on the all-ones BYPASS instruction. The caller supplies the three opcodes, the instruction register length and the payload byte count at the start request. The payload bytes arrive on a valid/ready byte stream.

The engine sits below this block and owns the TAP state walk, TCK and TDI. The sequencer hands it one command at a time over a valid/ready command port. A command has a kind (instruction shift, data shift or idle run), a length and an instruction value. After accepting a command, the engine reports its completion with `eng_done` or its failure with `eng_err`. During the data step, payload bytes flow to the engine with their bit order reversed. This is needed because the configuration port takes each byte most significant bit first, while JTAG shifts least significant bit first. No TDO data is returned or used.

Top module: `cfg_load_seq`

## Requirements
- R1: A `start` while idle is refused with a one-cycle `fail` pulse in the next cycle, and no command is issued and no byte is consumed, when any of `op_clear`, `op_cfgin`, `op_go` is zero, when `byte_total` is zero, or when `ir_len` is outside 1..32.
- R2: An accepted load issues exactly these commands in this order: IR `op_clear`, IDLE, IR `op_cfgin`, DR, IR `op_go`, IDLE, IR bypass. Kind codes are IR=0, DR=1, IDLE=2.
- R3: The first IDLE command has a length of 10000 cycles and the second has a length of 2000 cycles.
- R4: Every IR command has `cmd_len` equal to `ir_len` and `cmd_ir` equal to the opcode captured at start.
- R5: The payload goes out as one DR command with `cmd_len` equal to 8 times `byte_total`.
- R6: Each payload byte appears on `sh_data` with its bits mirrored, so that `sh_data[i]` equals `src_data[7-i]`.
- R7: `src_ready` is high only during the DR step, and no more than `byte_total` bytes are taken from the stream, even when the engine keeps asking for more.
- R8: The bypass command carries ones in bits 0..`ir_len`-1 and zeros above them, which gives 32 ones when `ir_len` is 32.
- R9: An `eng_err` on a step that has been issued ends the load. It gives a one-cycle `fail` pulse, returns to idle, and issues no further commands.
- R10: `done` pulses for one cycle in the cycle after the bypass command completes. It never coincides with `fail`.
- R11: `step` reads 0 when idle, and reads 1 through 7 for the seven commands in the order of R2. `busy` is high exactly when `step` is non-zero. Both are 0 after reset.
- R12: `cmd_valid` stays high, with `cmd_kind`, `cmd_len` and `cmd_ir` unchanged, until `cmd_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (sampled only while idle) |
| op_clear | input | 32 | Clear-configuration opcode |
| op_cfgin | input | 32 | Configuration-input opcode |
| op_go | input | 32 | Start opcode |
| ir_len | input | 6 | Instruction register length, 1..32 |
| byte_total | input | 16 | Payload length in bytes |
| src_valid | input | 1 | Payload byte valid |
| src_data | input | 8 | Payload byte |
| src_ready | output | 1 | Payload byte taken |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_kind | output | 2 | 0 IR shift, 1 DR shift, 2 idle run |
| cmd_len | output | 19 | Bits to shift or idle cycles to run |
| cmd_ir | output | 32 | Instruction value for IR commands |
| sh_valid | output | 1 | Reversed payload byte valid to the engine |
| sh_data | output | 8 | Reversed payload byte |
| sh_ready | input | 1 | Engine takes the byte |
| eng_done | input | 1 | Engine finished the accepted command |
| eng_err | input | 1 | Engine failed the accepted command |
| busy | output | 1 | Load in progress |
| step | output | 3 | Current step code |
| done | output | 1 | Load completed (one cycle) |
| fail | output | 1 | Load refused or aborted (one cycle) |

## Verification
The assertions assume that the engine follows its handshake. It raises `eng_done` or `eng_err` only for a command it has accepted, raises them once per command and never together, and does not pull payload bytes outside a data command. The bench engine model keeps to this. It completes each command a few cycles after accepting it, and it holds `cmd_ready` low for two cycles after every completion so that the hold rule is exercised. It also keeps asking for bytes for two cycles past the end of the payload, to probe the byte limit. The sweeps cover every instruction length from 1 to 32, errors injected at each of the seven steps, and every refusal cause.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CLR_IR   = 3'd1,
    ST_CLR_WAIT = 3'd2,
    ST_CFG_IR   = 3'd3,
    ST_PAYLOAD  = 3'd4,
    ST_GO_IR    = 3'd5,
    ST_GO_WAIT  = 3'd6,
    ST_BYP_IR   = 3'd7
  } step_e;

  typedef enum logic [1:0] {
    K_IR   = 2'd0,
    K_DR   = 2'd1,
    K_IDLE = 2'd2
  } kind_e;

endpackage

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl
  import cfgseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  req_ok,
  input  logic  cmd_ready,
  input  logic  eng_done,
  input  logic  eng_err,
  output step_e step_q,
  output logic  issued_q,
  output logic  done_q,
  output logic  fail_q,
  output logic  accept
);

  step_e step_n;
  logic  issued_n;
  logic  done_n;
  logic  fail_n;

  assign accept = start && (step_q == ST_IDLE) && req_ok;

  always_comb begin
    step_n   = step_q;
    issued_n = issued_q;
    done_n   = 1'b0;
    fail_n   = 1'b0;
    if (step_q == ST_IDLE) begin
      if (start) begin
        if (req_ok) begin
          step_n   = ST_CLR_IR;
          issued_n = 1'b0;
        end else begin
          fail_n = 1'b1;
        end
      end
    end else if (!issued_q) begin
      if (cmd_ready) issued_n = 1'b1;
    end else if (eng_err) begin
      step_n   = ST_IDLE;
      issued_n = 1'b0;
      fail_n   = 1'b1;
    end else if (eng_done) begin
      issued_n = 1'b0;
      if (step_q == ST_BYP_IR) begin
        step_n = ST_IDLE;
        done_n = 1'b1;
      end else begin
        step_n = step_e'(step_q + 3'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= ST_IDLE;
      issued_q <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      step_q   <= step_n;
      issued_q <= issued_n;
      done_q   <= done_n;
      fail_q   <= fail_n;
    end
  end

  assert_done_fail_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && fail_q));

  assert_done_after_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(step_q) == ST_BYP_IR) && (step_q == ST_IDLE));

  assert_fail_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> (step_q == ST_IDLE));

endmodule

// File: rtl/cfgseq_cmd.sv
module cfgseq_cmd
  import cfgseq_pkg::*;
#(
  parameter int IR_MAX   = 32,
  parameter int CNT_W    = 16,
  parameter int LEN_W    = 19,
  parameter int IRL_W    = 6,
  parameter int CLR_IDLE = 10000,
  parameter int GO_IDLE  = 2000
) (
  input  step_e             step,
  input  logic [IR_MAX-1:0] op_clr,
  input  logic [IR_MAX-1:0] op_cfg,
  input  logic [IR_MAX-1:0] op_go,
  input  logic [IRL_W-1:0]  irl,
  input  logic [CNT_W-1:0]  total,
  output logic [1:0]        kind,
  output logic [LEN_W-1:0]  len,
  output logic [IR_MAX-1:0] ir
);

  logic [IR_MAX-1:0] byp_mask;

  for (genvar g = 0; g < IR_MAX; g++) begin : g_byp
    assign byp_mask[g] = (irl > IRL_W'(g));
  end

  always_comb begin
    kind = K_IR;
    len  = LEN_W'(irl);
    ir   = '0;
    case (step)
      ST_CLR_IR:   ir = op_clr;
      ST_CLR_WAIT: begin kind = K_IDLE; len = LEN_W'(CLR_IDLE); end
      ST_CFG_IR:   ir = op_cfg;
      ST_PAYLOAD:  begin kind = K_DR; len = LEN_W'({total, 3'b000}); end
      ST_GO_IR:    ir = op_go;
      ST_GO_WAIT:  begin kind = K_IDLE; len = LEN_W'(GO_IDLE); end
      ST_BYP_IR:   ir = byp_mask;
      default:     len = '0;
    endcase
  end

endmodule

// File: rtl/cfgseq_payload.sv
module cfgseq_payload #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             active,
  input  logic [CNT_W-1:0] total,
  input  logic             src_valid,
  input  logic [7:0]       src_data,
  output logic             src_ready,
  output logic             sh_valid,
  output logic [7:0]       sh_data,
  input  logic             sh_ready
);

  logic [CNT_W-1:0] sent_q;
  logic [CNT_W-1:0] sent_n;
  logic             sent_en;
  logic             open;
  logic             fire;

  assign open      = active && (sent_q != total);
  assign sh_valid  = src_valid && open;
  assign src_ready = sh_ready && open;
  assign fire      = sh_valid && sh_ready;

  for (genvar b = 0; b < 8; b++) begin : g_rev
    assign sh_data[b] = src_data[7-b];
  end

  always_comb begin
    sent_en = clr || fire;
    sent_n  = clr ? '0 : sent_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sent_q <= '0;
    else if (sent_en) sent_q <= sent_n;
  end

  assert_ready_in_payload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> active);

  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && active) |-> (sent_q <= total));

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfgseq_pkg::*;
#(
  parameter int IR_MAX   = 32,
  parameter int CNT_W    = 16,
  parameter int CLR_IDLE = 10000,
  parameter int GO_IDLE  = 2000,
  localparam int IRL_W    = $clog2(IR_MAX + 1),
  localparam int IDLE_MAX = (CLR_IDLE > GO_IDLE) ? CLR_IDLE : GO_IDLE,
  localparam int IDLE_W   = $clog2(IDLE_MAX + 1),
  localparam int LEN_W    = ((CNT_W + 3) > IDLE_W) ? (CNT_W + 3) : IDLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IR_MAX-1:0] op_clear,
  input  logic [IR_MAX-1:0] op_cfgin,
  input  logic [IR_MAX-1:0] op_go,
  input  logic [IRL_W-1:0]  ir_len,
  input  logic [CNT_W-1:0]  byte_total,
  input  logic              src_valid,
  input  logic [7:0]        src_data,
  output logic              src_ready,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [IR_MAX-1:0] cmd_ir,
  output logic              sh_valid,
  output logic [7:0]        sh_data,
  input  logic              sh_ready,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic              busy,
  output logic [2:0]        step,
  output logic              done,
  output logic              fail
);

  step_e             step_q;
  logic              issued_q;
  logic              accept;
  logic              req_ok;
  logic [IR_MAX-1:0] op_clr_q;
  logic [IR_MAX-1:0] op_cfg_q;
  logic [IR_MAX-1:0] op_go_q;
  logic [IRL_W-1:0]  irl_q;
  logic [CNT_W-1:0]  total_q;

  assign req_ok = (op_clear != '0) && (op_cfgin != '0) && (op_go != '0) &&
                  (byte_total != '0) && (ir_len != '0) &&
                  (ir_len <= IRL_W'(IR_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_clr_q <= '0;
      op_cfg_q <= '0;
      op_go_q  <= '0;
      irl_q    <= '0;
      total_q  <= '0;
    end else if (accept) begin
      op_clr_q <= op_clear;
      op_cfg_q <= op_cfgin;
      op_go_q  <= op_go;
      irl_q    <= ir_len;
      total_q  <= byte_total;
    end
  end

  cfgseq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_ok    (req_ok),
    .cmd_ready (cmd_ready),
    .eng_done  (eng_done),
    .eng_err   (eng_err),
    .step_q    (step_q),
    .issued_q  (issued_q),
    .done_q    (done),
    .fail_q    (fail),
    .accept    (accept)
  );

  cfgseq_cmd #(
    .IR_MAX   (IR_MAX),
    .CNT_W    (CNT_W),
    .LEN_W    (LEN_W),
    .IRL_W    (IRL_W),
    .CLR_IDLE (CLR_IDLE),
    .GO_IDLE  (GO_IDLE)
  ) u_cmd (
    .step   (step_q),
    .op_clr (op_clr_q),
    .op_cfg (op_cfg_q),
    .op_go  (op_go_q),
    .irl    (irl_q),
    .total  (total_q),
    .kind   (cmd_kind),
    .len    (cmd_len),
    .ir     (cmd_ir)
  );

  cfgseq_payload #(
    .CNT_W (CNT_W)
  ) u_pay (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept),
    .active    (step_q == ST_PAYLOAD),
    .total     (total_q),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_ready (src_ready),
    .sh_valid  (sh_valid),
    .sh_data   (sh_data),
    .sh_ready  (sh_ready)
  );

  assign busy      = (step_q != ST_IDLE);
  assign step      = step_q;
  assign cmd_valid = busy && !issued_q;

  assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_kind) &&
                                  $stable(cmd_len) && $stable(cmd_ir));

  assert_bypass_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (step_q == ST_BYP_IR)) |->
      ($countones(cmd_ir) == int'(irl_q)) && (cmd_kind == K_IR));

  assert_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ((op_clear == '0) || (op_cfgin == '0) || (op_go == '0) ||
                        (byte_total == '0))) |=> fail && !busy);

  assert_err_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && issued_q && eng_err) |=> fail && !busy && !cmd_valid);

endmodule

// File: tb/sim_cfg_load_seq.sv
module sim_cfg_load_seq;

  localparam int CLK_P = 10;
  localparam int IRM   = 32;
  localparam int CW    = 16;
  localparam int LW    = 19;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [IRM-1:0] op_clear, op_cfgin, op_go;
  logic [5:0]    ir_len;
  logic [CW-1:0] byte_total;
  logic          src_valid;
  logic [7:0]    src_data;
  logic          src_ready;
  logic          cmd_valid, cmd_ready;
  logic [1:0]    cmd_kind;
  logic [LW-1:0] cmd_len;
  logic [IRM-1:0] cmd_ir;
  logic          sh_valid, sh_ready;
  logic [7:0]    sh_data;
  logic          eng_done, eng_err;
  logic          busy, done, fail;
  logic [2:0]    step;

  cfg_load_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_clear(op_clear), .op_cfgin(op_cfgin), .op_go(op_go),
    .ir_len(ir_len), .byte_total(byte_total),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_len(cmd_len), .cmd_ir(cmd_ir),
    .sh_valid(sh_valid), .sh_data(sh_data), .sh_ready(sh_ready),
    .eng_done(eng_done), .eng_err(eng_err),
    .busy(busy), .step(step), .done(done), .fail(fail)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // engine and source model state
  bit            env_on = 0;
  bit            e_busy = 0;
  bit            e_dr = 0;
  int            e_cnt = 0, e_tail = 0, e_got = 0, e_wait = 0;
  int            e_len = 0;
  int            err_at = -1;
  int            cmd_cnt = 0;
  bit            seen = 0;
  logic [1:0]    s_kind;
  logic [LW-1:0] s_len;
  logic [IRM-1:0] s_ir;
  logic [1:0]    rec_kind [8];
  logic [LW-1:0] rec_len  [8];
  logic [IRM-1:0] rec_ir  [8];
  logic [2:0]    rec_step [8];
  logic [7:0]    byte_rec [16];
  int            byte_cnt = 0;
  logic [7:0]    src_mem  [16];
  int            src_idx = 0, src_lim = 0;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mirror(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  always @(negedge clk) begin
    if (env_on) begin
      bit fin;
      fin = 0;
      eng_done = 1'b0;
      eng_err  = 1'b0;
      if (e_busy) begin
        if (!e_dr) begin
          if (e_cnt == 0) fin = 1; else e_cnt--;
        end else if (e_got * 8 >= e_len) begin
          if (e_tail == 0) fin = 1; else e_tail--;
        end
        if (fin) begin
          if (cmd_cnt - 1 == err_at) eng_err = 1'b1; else eng_done = 1'b1;
          e_busy = 0;
          e_wait = 2;
        end
      end
      cmd_ready = (!e_busy && e_wait == 0);
      if (!e_busy && e_wait > 0) e_wait--;
      sh_ready  = e_busy && e_dr;
      src_valid = (src_idx < src_lim);
      src_data  = src_mem[src_idx % 16];
      #1;
      if (cmd_valid) begin
        if (!seen) begin
          seen = 1; s_kind = cmd_kind; s_len = cmd_len; s_ir = cmd_ir;
        end
        if (cmd_ready) begin
          // R12: fields held while waiting for acceptance
          chk(s_kind == cmd_kind && s_len == cmd_len && s_ir == cmd_ir,
              "R12 command held", cmd_ir, s_ir);
          if (cmd_cnt < 8) begin
            rec_kind[cmd_cnt] = cmd_kind;
            rec_len[cmd_cnt]  = cmd_len;
            rec_ir[cmd_cnt]   = cmd_ir;
            rec_step[cmd_cnt] = step;
          end
          cmd_cnt++;
          seen   = 0;
          e_busy = 1;
          e_dr   = (cmd_kind == 2'd1);
          e_len  = int'(cmd_len);
          e_cnt  = 2;
          e_tail = 2;
          e_got  = 0;
        end
      end
      if (sh_valid && sh_ready) begin
        if (byte_cnt < 16) byte_rec[byte_cnt] = sh_data;
        byte_cnt++;
        e_got++;
      end
      if (src_valid && src_ready) src_idx++;
    end
  end

  task automatic run_load(input logic [31:0] oc, input logic [31:0] ofg,
                          input logic [31:0] og, input int irl, input int n,
                          input int errk);
    bit saw_done, saw_fail, ok_req;
    int exp_cmds;
    logic [31:0] byp;
    @(negedge clk);
    #2;
    cmd_cnt = 0; byte_cnt = 0; src_idx = 0; src_lim = n + 2; err_at = errk; seen = 0;
    for (int j = 0; j < 16; j++) src_mem[j] = 8'(j * 53 + irl * 7 + 29);
    op_clear = oc; op_cfgin = ofg; op_go = og;
    ir_len = 6'(irl); byte_total = CW'(n);
    start = 1'b1;
    @(negedge clk);
    #2;
    start = 1'b0;
    saw_done = 0; saw_fail = 0;
    for (int c = 0; c < 3000; c++) begin
      if (done) saw_done = 1;
      if (fail) saw_fail = 1;
      if (done || fail) break;
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    #2;
    chk(!done && !fail && !busy && step == 3'd0, "R10/R11 single pulse then idle",
        {done, fail, busy, step}, 0);
    ok_req = (oc != 0) && (ofg != 0) && (og != 0) && (n != 0) && (irl >= 1) && (irl <= 32);
    if (!ok_req) begin
      chk(saw_fail && !saw_done, "R1 refusal fail pulse", saw_fail, 1);
      chk(cmd_cnt == 0 && src_idx == 0, "R1 nothing issued", cmd_cnt + src_idx, 0);
      return;
    end
    exp_cmds = (errk < 0) ? 7 : errk + 1;
    chk(cmd_cnt == exp_cmds, "R2/R9 command count", cmd_cnt, exp_cmds);
    chk(saw_done == (errk < 0), "R10 done pulse", saw_done, errk < 0);
    chk(saw_fail == (errk >= 0), "R9 fail pulse", saw_fail, errk >= 0);
    byp = (irl == 32) ? 32'hFFFF_FFFF : ((32'h1 << irl) - 32'h1);
    for (int k = 0; k < exp_cmds && k < cmd_cnt; k++) begin
      chk(rec_step[k] == 3'(k + 1), "R11 step code", rec_step[k], k + 1);
      case (k)
        0: chk(rec_kind[k] == 0 && rec_len[k] == LW'(irl) && rec_ir[k] == oc,
               "R2/R4 clear IR", rec_ir[k], oc);
        1: chk(rec_kind[k] == 2 && rec_len[k] == 10000, "R3 first idle", rec_len[k], 10000);
        2: chk(rec_kind[k] == 0 && rec_len[k] == LW'(irl) && rec_ir[k] == ofg,
               "R2/R4 cfg IR", rec_ir[k], ofg);
        3: chk(rec_kind[k] == 1 && rec_len[k] == LW'(8 * n), "R5 payload DR", rec_len[k], 8 * n);
        4: chk(rec_kind[k] == 0 && rec_len[k] == LW'(irl) && rec_ir[k] == og,
               "R2/R4 start IR", rec_ir[k], og);
        5: chk(rec_kind[k] == 2 && rec_len[k] == 2000, "R3 second idle", rec_len[k], 2000);
        default: chk(rec_kind[k] == 0 && rec_len[k] == LW'(irl) && rec_ir[k] == byp,
               "R8 bypass IR", rec_ir[k], byp);
      endcase
    end
    if (errk < 0 || errk >= 3) begin
      chk(byte_cnt == n && src_idx == n, "R7 byte count limit", byte_cnt, n);
      for (int j = 0; j < n && j < 16; j++)
        chk(byte_rec[j] == mirror(src_mem[j]), "R6 bit reversal", byte_rec[j], mirror(src_mem[j]));
    end else begin
      chk(byte_cnt == 0 && src_idx == 0, "R7/R9 no bytes before payload", byte_cnt, 0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    op_clear = '0; op_cfgin = '0; op_go = '0; ir_len = '0; byte_total = '0;
    src_valid = 1'b0; src_data = '0; cmd_ready = 1'b0; sh_ready = 1'b0;
    eng_done = 1'b0; eng_err = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk(!busy && step == 0 && !done && !fail && !cmd_valid && !src_ready && !sh_valid,
        "R11 reset state", {busy, step, done, fail}, 0);
    rst_n = 1'b1;
    env_on = 1;
    // basic load
    run_load(32'h0B, 32'h05, 32'h0C, 6, 4, -1);
    // R1 refusal causes
    run_load(32'h00, 32'h05, 32'h0C, 6, 4, -1);
    run_load(32'h0B, 32'h00, 32'h0C, 6, 4, -1);
    run_load(32'h0B, 32'h05, 32'h00, 6, 4, -1);
    run_load(32'h0B, 32'h05, 32'h0C, 6, 0, -1);
    run_load(32'h0B, 32'h05, 32'h0C, 0, 4, -1);
    run_load(32'h0B, 32'h05, 32'h0C, 33, 4, -1);
    // R8 sweep of every instruction length
    for (int l = 1; l <= 32; l++)
      run_load(32'h0B + l, 32'h05 ^ (l << 4), 32'h0C, l, (l % 5) + 1, -1);
    // R9 error injected at each step
    for (int k = 0; k < 7; k++)
      run_load(32'h0B, 32'h05, 32'h0C, 6, 3, k);
    // load after an abort still works
    run_load(32'hFFFF_FFFE, 32'h1, 32'h8000_0000, 32, 7, -1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule